// File: doc/BRIEF.md
# Cascadable Serial Configuration Store

This block models a read-only configuration store that streams a fixed image to a loading device, one element per clock. The loader supplies the clock and samples each element on the rising edge that follows its presentation. The same store can present data one bit at a time on a single line, most significant bit first, or a whole byte at a time on eight lines. The choice is made by a mode input that stays fixed for a whole pass.

Several stores can share one clock and one data bus. Each store's chain-enable output feeds the enable input of the next store. When a store has handed over its last element it stops driving the bus and pulls its chain-enable output low, so the next store takes over without a gap. A combined output-enable/reset input, whose active level is chosen by a parameter, stops all driving and returns the counters and the hand-off flag to the start. The image is computed from a seed parameter. The tri-state bus is modelled as a data vector plus a drive-enable flag.

Top module: `cfg_stream_rom`

## Requirements
- R1: The active level of `oe_rst` is set by parameter `RST_ACTIVE_HIGH` (1: high resets, 0: low resets). A reset held across a rising edge makes the next pass start at byte 0, bit 0.
- R2: While reset is asserted, `dout_en` is 0 and `chain_n` is 1, combinationally and without waiting for a clock edge.
- R3: While `ce_n` is 1, `dout_en` is 0 and the position counters hold. After `ce_n` returns to 0, the stream resumes with the element that was being presented when it was paused.
- R4: The byte stored at address a is (a*29 + SEED) mod 256. In serial mode (`par_mode`=0), address a and bit b (0..7) place bit 7-b of that byte on `dout[0]`, and `dout[7:1]` is 0.
- R5: In parallel mode (`par_mode`=1), the whole byte at the current address is on `dout[7:0]`, and the address advances by one on each enabled rising edge.
- R6: The element at address `LAST_ADDR` (in serial mode its bit 7) is the last one presented. On the rising edge that consumes it, the store sets its done state: `dout_en` goes to 0, and `chain_n` goes to 0 while `ce_n` is 0.
- R7: Once done, further clock edges leave `dout_en` at 0 and `chain_n` at 0 until a reset.
- R8: A reset after the done state drives `chain_n` back to 1, and the next pass begins again at the first element.
- R9: In a chain of two stores whose data lines are joined, at most one store asserts `dout_en` in any cycle. The joined stream is the first store's image followed by the second's with no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock from the loading device |
| ce_n | input | 1 | Chip enable, active low; fed by the upstream store's `chain_n` |
| oe_rst | input | 1 | Combined output enable and reset; active level set by `RST_ACTIVE_HIGH` |
| par_mode | input | 1 | 0: one bit per clock on `dout[0]`; 1: one byte per clock |
| dout | output | 8 | Data presented to the shared bus |
| dout_en | output | 1 | High when this store drives the bus |
| chain_n | output | 1 | Low once this store has delivered its last element; enables the next store |

## Verification
Two events can fall on the same clock edge: the edge that would consume the last element, and a pause through `ce_n` (or a reset). A pause on that edge must stop the store from entering the done state. The bench provokes this by raising the head store's `ce_n` exactly while the head presents its last element, in both modes. It then holds the pause for several cycles and requires that the downstream store never drives. After the pause it requires that the same last element reappears and that only then does the hand-off to the second store occur. The joined bus is compared, element by element, with a stream the bench computes from the byte formula.

// File: rtl/cfg_rom_pkg.sv
package cfg_rom_pkg;

  // Stored image: byte at address a, derived from a seed.
  function automatic logic [7:0] rom_byte(input int unsigned a, input int unsigned seed);
    int unsigned v;
    v = a * 29 + seed;
    return v[7:0];
  endfunction

  // Serial element: bit (7 - b) of the byte, MSB first.
  function automatic logic serial_bit(input logic [7:0] byte_v, input logic [2:0] b);
    return byte_v[3'd7 - b];
  endfunction

endpackage

// File: rtl/cfg_seq_counter.sv
module cfg_seq_counter #(
  parameter int DEPTH     = 16,
  parameter int LAST_ADDR = DEPTH - 1,
  parameter int AW        = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          par_mode,
  output logic [AW-1:0] addr,
  output logic [2:0]    bit_idx,
  output logic          done,
  output logic          at_last,
  output logic          step
);

  localparam logic [AW-1:0] LAST_A = AW'(LAST_ADDR);

  assign at_last = (addr == LAST_A) && (par_mode || bit_idx == 3'd7);
  assign step    = enable && !done;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr    <= '0;
      bit_idx <= '0;
      done    <= 1'b0;
    end else if (step) begin
      if (at_last) begin
        done <= 1'b1;
      end else if (par_mode) begin
        addr <= addr + 1'b1;
      end else begin
        bit_idx <= bit_idx + 3'd1;
        if (bit_idx == 3'd7) addr <= addr + 1'b1;
      end
    end
  end

  // R3: counters hold while not enabled
  p_hold_when_off_r3: assert property (@(posedge clk) disable iff (rst)
    !enable |=> $stable(addr) && $stable(bit_idx));

  // R6: consuming the last element enters the done state
  p_done_at_last_r6: assert property (@(posedge clk) disable iff (rst)
    (step && at_last) |=> done);

  // R7: done is sticky until reset
  p_done_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  // R5: parallel mode advances one address per enabled edge
  p_addr_advance_r5: assert property (@(posedge clk) disable iff (rst)
    (step && par_mode && !at_last) |=> addr == $past(addr) + 1'b1);

endmodule

// File: rtl/cfg_out_mux.sv
module cfg_out_mux
  import cfg_rom_pkg::*;
#(
  parameter int SEED = 5,
  parameter int AW   = 4
) (
  input  logic [AW-1:0] addr,
  input  logic [2:0]    bit_idx,
  input  logic          par_mode,
  output logic [7:0]    dout
);

  logic [7:0] cur_byte;

  always_comb begin
    cur_byte = rom_byte(int'(addr), SEED);
    if (par_mode) dout = cur_byte;
    else          dout = {7'b0, serial_bit(cur_byte, bit_idx)};
  end

endmodule

// File: rtl/cfg_stream_rom.sv
module cfg_stream_rom #(
  parameter int DEPTH           = 16,
  parameter int LAST_ADDR       = DEPTH - 1,
  parameter int SEED            = 5,
  parameter bit RST_ACTIVE_HIGH = 1'b1
) (
  input  logic       clk,
  input  logic       ce_n,
  input  logic       oe_rst,
  input  logic       par_mode,
  output logic [7:0] dout,
  output logic       dout_en,
  output logic       chain_n
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic          rst_int;
  logic          enable;
  logic [AW-1:0] addr;
  logic [2:0]    bit_idx;
  logic          done;
  logic          at_last;
  logic          step;

  generate
    if (RST_ACTIVE_HIGH) begin : g_rst_hi
      assign rst_int = oe_rst;
    end else begin : g_rst_lo
      assign rst_int = !oe_rst;
    end
  endgenerate

  assign enable = !ce_n && !rst_int;

  cfg_seq_counter #(.DEPTH(DEPTH), .LAST_ADDR(LAST_ADDR), .AW(AW)) u_cnt (
    .clk(clk), .rst(rst_int), .enable(enable), .par_mode(par_mode),
    .addr(addr), .bit_idx(bit_idx), .done(done), .at_last(at_last), .step(step)
  );

  cfg_out_mux #(.SEED(SEED), .AW(AW)) u_mux (
    .addr(addr), .bit_idx(bit_idx), .par_mode(par_mode), .dout(dout)
  );

  assign dout_en = enable && !done;
  assign chain_n = !done || ce_n || rst_int;

  // R2 / R8: reset silences the store and restores the chain output
  always_comb begin
    if (rst_int) a_reset_quiet_r2: assert (chain_n && !dout_en);
  end

  // R6: a finished store never drives
  p_no_drive_when_done_r6: assert property (@(posedge clk) disable iff (rst_int)
    done |-> !dout_en);

  // R4: serial mode uses only the low line
  p_serial_upper_zero_r4: assert property (@(posedge clk) disable iff (rst_int)
    (!par_mode && dout_en) |-> dout[7:1] == 7'd0);

  // R9: driving and handing off are exclusive
  p_drive_or_pass_r9: assert property (@(posedge clk) disable iff (rst_int)
    dout_en |-> chain_n);

endmodule

// File: tb/tb_cfg_stream_rom.sv
module tb_cfg_stream_rom;

  localparam int DEPTH  = 4;
  localparam int SEED_A = 5;
  localparam int SEED_B = 200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b0;
  logic par_mode = 1'b0;

  logic [7:0] dout_a, dout_b;
  logic       en_a, en_b, chain_a, chain_b;
  logic [7:0] bus;

  int vectors = 0;
  int fails   = 0;

  always #10 clk = ~clk;

  // Head store resets on a high level; tail store on a low level (R1).
  cfg_stream_rom #(.DEPTH(DEPTH), .SEED(SEED_A), .RST_ACTIVE_HIGH(1'b1)) dut (
    .clk(clk), .ce_n(ce_n), .oe_rst(rst), .par_mode(par_mode),
    .dout(dout_a), .dout_en(en_a), .chain_n(chain_a));

  cfg_stream_rom #(.DEPTH(DEPTH), .SEED(SEED_B), .RST_ACTIVE_HIGH(1'b0)) dut_b (
    .clk(clk), .ce_n(chain_a), .oe_rst(!rst), .par_mode(par_mode),
    .dout(dout_b), .dout_en(en_b), .chain_n(chain_b));

  assign bus = en_a ? dout_a : (en_b ? dout_b : 8'h00);

  function automatic int exp_byte(input int a, input int seed);
    return (a * 29 + seed) % 256;
  endfunction

  function automatic int exp_elem(input int i, input bit m);
    int n, d, k, seed, v;
    n = m ? DEPTH : DEPTH * 8;
    d = i / n;
    k = i % n;
    seed = (d == 0) ? SEED_A : SEED_B;
    if (m) return exp_byte(k, seed);
    v = exp_byte(k / 8, seed);
    return (v >> (7 - (k % 8))) & 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_mode(input bit m);
    int n;
    n = m ? DEPTH : DEPTH * 8;
    @(negedge clk);
    rst = 1'b1; ce_n = 1'b0; par_mode = m;
    #1;
    chk(!en_a && !en_b, "R2", {en_a, en_b}, 0);
    tick();
    tick();
    chk(chain_a && chain_b, "R8", {chain_a, chain_b}, 3);
    rst = 1'b0;
    #1;
    chk(bus == 8'(exp_elem(0, m)), "R1", bus, exp_elem(0, m));
    for (int i = 0; i < 2 * n; i++) begin
      if (i == n - 1 || (!m && i == 5)) begin
        // pause; at i == n-1 this lands on the edge of the last element
        ce_n = 1'b1;
        #1;
        for (int c = 0; c < 3; c++) begin
          chk(!en_a && !en_b, "R3", {en_a, en_b}, 0);
          tick();
        end
        ce_n = 1'b0;
        #1;
      end
      chk($countones({en_a, en_b}) == 1, "R9", {en_a, en_b}, (i < n) ? 2 : 1);
      chk(bus == 8'(exp_elem(i, m)), m ? "R5" : "R4", bus, exp_elem(i, m));
      if (!m) chk((en_a ? dout_a[7:1] : dout_b[7:1]) == 7'd0, "R4", bus, exp_elem(i, m));
      tick();
    end
    chk(!en_a && !en_b && !chain_a && !chain_b, "R6",
        {en_a, en_b, chain_a, chain_b}, 0);
    for (int c = 0; c < 4; c++) begin
      tick();
      chk(!en_a && !en_b && !chain_a && !chain_b, "R7",
          {en_a, en_b, chain_a, chain_b}, 0);
    end
    rst = 1'b1;
    #1;
    chk(chain_a && chain_b && !en_a && !en_b, "R8", {en_a, en_b, chain_a, chain_b}, 3);
    tick();
    rst = 1'b0;
    #1;
    chk(en_a && !en_b && bus == 8'(exp_elem(0, m)), "R8", bus, exp_elem(0, m));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    run_mode(1'b0);
    run_mode(1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule